// File: doc/BRIEF.md
# Supervisor reset and watchdog sequencer

This block drives an active-low reset line for a processor. It takes four inputs: a supply-good flag from an external comparator, an active-low manual reset request, a watchdog kick strobe and a watchdog enable. It holds the processor in reset whenever the supply is bad or a manual reset is requested. After the cause clears, it releases the processor once a programmable delay has passed. While the processor runs, the block expects a periodic rising edge on the kick input. If no qualified kick arrives in time, the block issues a short reset pulse and then restarts the watchdog.

All timing derives from one run-time base period, given in clock cycles. One base period is both the long release delay and the watchdog timeout. A tenth of it, and never less than one cycle, is the short pulse that follows a timeout. The kick, manual reset and enable inputs are synchronized by two flops each and then filtered. The supply flag is taken as already synchronous. A parameter chooses whether the enable input is active-high or active-low.

Top module: `supervisor_seq`

## Requirements
- R1: While supply_ok is low, rst_out_n is low in the same cycle, whatever the kick, manual reset and enable inputs are doing. After the asynchronous reset, rst_out_n is low.
- R2: The cycle supply_ok is first sampled high starts the long hold. rst_out_n rises on exactly the base_period-th rising clock edge after that.
- R3: While released with the watchdog on, a kick that goes high restarts the timeout 2+KICK_MIN edges after it rises. A kick that stays high or stays low causes no further restart. Without a restart, rst_out_n falls on the base_period-th edge after release.
- R4: A timeout holds rst_out_n low for max(1, base_period/10) edges. rst_out_n is then released and a fresh timeout starts from zero.
- R5: With no kicks, the output repeats a cycle of base_period edges high followed by the short hold low.
- R6: mr_n held low for MR_MIN or more synchronized cycles drives rst_out_n low 2+MR_MIN edges after mr_n falls. After mr_n rises again, rst_out_n rises 3+base_period edges later.
- R7: With the watchdog disabled, rst_out_n stays high indefinitely. Supply loss still forces it low, and supply return still applies the long hold.
- R8: When the watchdog is re-enabled while released, the next timeout falls base_period+2 edges after the enable change. If enable and supply_ok rise together, the long hold applies, followed by a full timeout.
- R9: With EN_ACTIVE_HIGH=0, the enable input enables the watchdog when low. The output then matches the active-high variant driven with the inverted enable.
- R10: A kick high for fewer than KICK_MIN synchronized cycles does not restart the timeout. An mr_n low pulse shorter than MR_MIN synchronized cycles has no effect on rst_out_n.
- R11: Kicks that qualify while rst_out_n is low are discarded. The timeout counts from release.
- R12: A base_period of 0 behaves as 1 for the long hold, the timeout and the short hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok | input | 1 | Supply-good flag, synchronous, high when the supply is good |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| kick | input | 1 | Watchdog kick, acts on its rising edge, asynchronous |
| wd_en | input | 1 | Watchdog enable, polarity set by EN_ACTIVE_HIGH, asynchronous |
| base_period | input | CNT_W | Base period in clock cycles |
| rst_out_n | output | 1 | Active-low reset to the processor |

## Verification
The assertions assume that base_period changes only while supply_ok is low. The timeout and minimum-hold bounds are measured against the value in force when the counting started. The stimulus therefore loads each new period only during a supply outage. It drives the asynchronous inputs at falling clock edges only and gives every pulse a whole number of cycles. Each kick and manual reset pulse is either clearly below or clearly at its qualifying width, so the expected edge counts follow from the synchronizer and filter latencies stated in R3, R6 and R8.

// File: rtl/supervisor_seq.sv
module supervisor_seq #(
  parameter int CNT_W = 16,
  parameter int KICK_MIN = 2,
  parameter int MR_MIN = 4,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             supply_ok,
  input  logic             mr_n,
  input  logic             kick,
  input  logic             wd_en,
  input  logic [CNT_W-1:0] base_period,
  output logic             rst_out_n
);

  localparam int KW = $clog2(KICK_MIN + 1);
  localparam int MW = $clog2(MR_MIN + 1);
  localparam bit EN_OFF = ~EN_ACTIVE_HIGH;

  typedef enum logic [1:0] {S_LONG, S_RUN, S_SHORT} seq_t;

  logic [1:0] kick_q, mr_q, en_q;
  logic [KW-1:0] kick_run;
  logic [MW-1:0] mr_run;
  logic kick_evt, mr_hold, wd_on;
  logic [CNT_W-1:0] per_eff, short_raw, short_eff, tmr;
  seq_t state;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      kick_q <= 2'b00;
      mr_q   <= 2'b11;
      en_q   <= {EN_OFF, EN_OFF};
    end else begin
      kick_q <= {kick_q[0], kick};
      mr_q   <= {mr_q[0], mr_n};
      en_q   <= {en_q[0], wd_en};
    end
  end

  assign kick_evt = kick_q[1] && (kick_run == KW'(KICK_MIN - 1));
  assign mr_hold  = (mr_run == MW'(MR_MIN));
  assign wd_on    = (en_q[1] == EN_ACTIVE_HIGH);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) kick_run <= '0;
    else if (!kick_q[1]) kick_run <= '0;
    else if (kick_run != KW'(KICK_MIN)) kick_run <= kick_run + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) mr_run <= '0;
    else if (mr_q[1]) mr_run <= '0;
    else if (!mr_hold) mr_run <= mr_run + 1'b1;
  end

  assign per_eff   = (base_period == '0) ? CNT_W'(1) : base_period;
  assign short_raw = per_eff / CNT_W'(10);
  assign short_eff = (short_raw == '0) ? CNT_W'(1) : short_raw;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= S_LONG;
      tmr   <= '0;
    end else if (!supply_ok || mr_hold) begin
      state <= S_LONG;
      tmr   <= '0;
    end else begin
      case (state)
        S_LONG:
          if (tmr >= per_eff - 1'b1) begin
            state <= S_RUN;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        S_RUN:
          if (!wd_on || kick_evt) tmr <= '0;
          else if (tmr >= per_eff - 1'b1) begin
            state <= S_SHORT;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        S_SHORT:
          if (tmr >= short_eff - 1'b1) begin
            state <= S_RUN;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        default: begin
          state <= S_LONG;
          tmr   <= '0;
        end
      endcase
    end
  end

  assign rst_out_n = (state == S_RUN) && supply_ok && !mr_hold;

endmodule

// File: rtl/supervisor_seq_chk.sv
module supervisor_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             arst_n,
  input logic             supply_ok,
  input logic             mr_hold,
  input logic             wd_on,
  input logic             kick_evt,
  input logic [CNT_W-1:0] per_eff,
  input logic [CNT_W-1:0] short_eff,
  input logic             rst_out_n
);

  logic [CNT_W:0] low_run, hi_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_run <= '0;
      hi_run  <= '0;
    end else begin
      if (rst_out_n) low_run <= '0;
      else if (low_run != {(CNT_W+1){1'b1}}) low_run <= low_run + 1'b1;
      if (rst_out_n && wd_on && !kick_evt) begin
        if (hi_run != {(CNT_W+1){1'b1}}) hi_run <= hi_run + 1'b1;
      end else hi_run <= '0;
    end
  end

  AST_SUPPLY_LOSS_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> !rst_out_n); // R1

  AST_MANUAL_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    mr_hold |=> !rst_out_n); // R6

  AST_MIN_LOW_SPAN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> (low_run >= {1'b0, short_eff})); // R4

  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    hi_run <= {1'b0, per_eff}); // R3

endmodule

bind supervisor_seq supervisor_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_hold(mr_hold),
  .wd_on(wd_on), .kick_evt(kick_evt), .per_eff(per_eff),
  .short_eff(short_eff), .rst_out_n(rst_out_n)
);

// File: tb/tb_supervisor_seq.sv
module tb_supervisor_seq;
  localparam int CNT_W = 8;
  localparam int KICK_MIN = 2;
  localparam int MR_MIN = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic mr_n = 1'b1;
  logic kick = 1'b0;
  logic wd_en = 1'b1;
  logic [CNT_W-1:0] base_period = CNT_W'(10);
  logic rst_out_n, rst_alt_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supervisor_seq #(.CNT_W(CNT_W), .KICK_MIN(KICK_MIN), .MR_MIN(MR_MIN), .EN_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_n(mr_n), .kick(kick),
    .wd_en(wd_en), .base_period(base_period), .rst_out_n(rst_out_n));

  supervisor_seq #(.CNT_W(CNT_W), .KICK_MIN(KICK_MIN), .MR_MIN(MR_MIN), .EN_ACTIVE_HIGH(1'b0)) dut_alt (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_n(mr_n), .kick(kick),
    .wd_en(~wd_en), .base_period(base_period), .rst_out_n(rst_alt_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_until(input logic lvl, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (rst_out_n !== lvl && n < 4000);
  endtask

  always @(posedge clk) begin
    if (arst_n && !done) begin
      #2;
      chk(rst_alt_n === rst_out_n, "R9 polarity", int'(rst_alt_n), int'(rst_out_n));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int plist[6] = '{0, 5, 10, 13, 27, 40};
    repeat (3) @(negedge clk);
    chk(rst_out_n === 1'b0, "R1 reset state", int'(rst_out_n), 0);
    arst_n = 1'b1;
    supply_ok = 1'b1;
    run_until(1'b1, n);
    chk(n == 10, "R2 power-on hold", n, 10);

    for (int i = 0; i < 6; i++) begin
      int p = plist[i];
      int eff = (p == 0) ? 1 : p;
      int sh = (eff / 10 == 0) ? 1 : eff / 10;
      string lt = (p == 0) ? "R12 long" : "R2 long";

      supply_ok = 1'b0;
      kick = 1'b1;
      mr_n = 1'b0;
      base_period = CNT_W'(p);
      #1;
      chk(rst_out_n === 1'b0, "R1 immediate", int'(rst_out_n), 0);
      repeat (3) tick();
      kick = 1'b0;
      mr_n = 1'b1;
      repeat (8) tick();
      chk(rst_out_n === 1'b0, "R1 held", int'(rst_out_n), 0);
      supply_ok = 1'b1;
      run_until(1'b1, n);
      chk(n == eff, lt, n, eff);
      run_until(1'b0, n);
      chk(n == eff, "R3 timeout no kick", n, eff);
      run_until(1'b1, n);
      chk(n == sh, "R4 short hold", n, sh);
      run_until(1'b0, n);
      chk(n == eff, "R5 repeat timeout", n, eff);
      run_until(1'b1, n);
      chk(n == sh, "R5 repeat short", n, sh);

      if (p >= 10) begin
        kick = 1'b1;
        tick();
        kick = 1'b0;
        run_until(1'b0, n);
        n++;
        chk(n == eff, "R10 narrow kick ignored", n, eff);
        run_until(1'b1, n);

        kick = 1'b1;
        run_until(1'b0, n);
        chk(n == 2 + KICK_MIN + eff, "R3 kick held high", n, 2 + KICK_MIN + eff);
        kick = 1'b0;
        run_until(1'b1, n);
        chk(n == sh, "R4 short after kick", n, sh);

        supply_ok = 1'b0;
        repeat (2) tick();
        supply_ok = 1'b1;
        kick = 1'b1;
        n = 0;
        repeat (KICK_MIN) begin
          tick();
          n++;
        end
        kick = 1'b0;
        while (rst_out_n === 1'b0 && n < 4000) begin
          tick();
          n++;
        end
        chk(n == eff, "R11 hold with kick", n, eff);
        run_until(1'b0, n);
        chk(n == eff, "R11 kick discarded", n, eff);
        run_until(1'b1, n);

        mr_n = 1'b0;
        run_until(1'b0, n);
        chk(n == 2 + MR_MIN, "R6 manual assert", n, 2 + MR_MIN);
        repeat (5) begin
          tick();
          chk(rst_out_n === 1'b0, "R6 manual held", int'(rst_out_n), 0);
        end
        mr_n = 1'b1;
        run_until(1'b1, n);
        chk(n == 3 + eff, "R6 manual release", n, 3 + eff);

        mr_n = 1'b0;
        repeat (MR_MIN - 1) begin
          tick();
          chk(rst_out_n === 1'b1, "R10 short manual", int'(rst_out_n), 1);
        end
        mr_n = 1'b1;
        repeat (4) begin
          tick();
          chk(rst_out_n === 1'b1, "R10 short manual", int'(rst_out_n), 1);
        end
        run_until(1'b0, n);
        chk(n == eff - (MR_MIN + 3), "R10 timer unaffected", n, eff - (MR_MIN + 3));
        run_until(1'b1, n);

        wd_en = 1'b0;
        n = 0;
        repeat (3 * eff) begin
          tick();
          if (rst_out_n !== 1'b1) n++;
        end
        chk(n == 0, "R7 disabled stays high", n, 0);
        supply_ok = 1'b0;
        #1;
        chk(rst_out_n === 1'b0, "R7 supply still monitored", int'(rst_out_n), 0);
        tick();
        supply_ok = 1'b1;
        run_until(1'b1, n);
        chk(n == eff, "R7 long hold while disabled", n, eff);
        n = 0;
        repeat (2 * eff) begin
          tick();
          if (rst_out_n !== 1'b1) n++;
        end
        chk(n == 0, "R7 no timeout", n, 0);
        wd_en = 1'b1;
        run_until(1'b0, n);
        chk(n == eff + 2, "R8 fresh timeout", n, eff + 2);
        run_until(1'b1, n);

        supply_ok = 1'b0;
        wd_en = 1'b0;
        repeat (4) tick();
        supply_ok = 1'b1;
        wd_en = 1'b1;
        run_until(1'b1, n);
        chk(n == eff, "R8 joint rise hold", n, eff);
        run_until(1'b0, n);
        chk(n == eff, "R8 joint rise timeout", n, eff);
        run_until(1'b1, n);
        chk(n == sh, "R4 short again", n, sh);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule